// File: doc/BRIEF.md
# Decimal Adjust Unit

This block corrects the result of a preceding binary addition so that it reads as decimal digits again. It has two modes. The unpacked mode treats the low accumulator byte as one decimal digit; it carries into a companion high byte. The packed mode treats the low accumulator byte as two decimal digits. The addition itself is done elsewhere. The unit receives the sum, the high byte and the auxiliary-carry and carry flags that the addition produced. It returns the corrected bytes and the new values of those two flags.

Every operation is presented with a one-cycle strobe. The corrected values are registered and appear on the outputs one clock later, together with a one-cycle output-valid pulse. Between strobes the outputs hold their last values.

Top module: `dec_adjust`

## Requirements
- R1: With op_i = 0 (unpacked mode), if the low nibble of lo_i is above 9 or af_i = 1, then lo_o = (lo_i + 6) & 0x0F, hi_o = hi_i + 1 (plus R2), and af_o = cf_o = 1.
- R2: In unpacked mode, when the R1 correction applies and lo_i > 0xF9, hi_o receives one further increment, so hi_o = hi_i + 2.
- R3: In unpacked mode, when neither R1 condition holds, lo_o = lo_i & 0x0F, hi_o = hi_i, and af_o = cf_o = 0 (example: lo_i = 0x66 gives lo_o = 0x06).
- R4: With op_i = 1 (packed mode), if the low nibble of lo_i is above 9 or af_i = 1, then 6 is added to the low byte and af_o = 1; otherwise nothing is added at this step and af_o = 0.
- R5: In packed mode, if (lo_i & 0xF0) > 0x90 or cf_i = 1, then 0x60 is added to the byte produced by R4 and cf_o = 1; otherwise cf_o = 0. Both tests use the incoming lo_i, af_i and cf_i, not the result of the R4 step.
- R6: In packed mode, hi_o = hi_i.
- R7: All byte arithmetic wraps modulo 256.
- R8: The results appear on the outputs on the first rising edge after a strobe on valid_i; valid_o is high for exactly that one cycle per strobe; while valid_i is low, all result outputs keep their values.
- R9: After reset, valid_o, lo_o, hi_o, af_o and cf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 1 | Mode: 0 unpacked, 1 packed |
| lo_i | input | 8 | Low accumulator byte (binary sum) |
| hi_i | input | 8 | High accumulator byte |
| af_i | input | 1 | Auxiliary carry from the addition |
| cf_i | input | 1 | Carry from the addition |
| valid_o | output | 1 | One-cycle result pulse |
| lo_o | output | 8 | Corrected low byte |
| hi_o | output | 8 | Corrected high byte |
| af_o | output | 1 | New auxiliary carry |
| cf_o | output | 1 | New carry |

## Verification
Each result is due exactly one rising edge after its strobe, with valid_o high in that same cycle. The driver changes inputs on falling edges and places the expected bytes and flags in a queue. The monitor samples on falling edges and pops one item whenever valid_o is high, so every comparison falls half a cycle after the edge that produced it. A valid_o with no queued item counts as a failure, and so does an item still queued at the end. Idle stretches after strobes confirm that the outputs hold their values.

// File: rtl/dec_adjust_pkg.sv
package dec_adjust_pkg;
  localparam int unsigned ACC_W = 8;
  localparam int unsigned NIB_W = ACC_W / 2;
  localparam int unsigned DIGIT_MAX = 9;

  typedef enum logic {
    OP_UNPACKED = 1'b0,
    OP_PACKED   = 1'b1
  } adj_op_e;

  typedef struct packed {
    logic [ACC_W-1:0] lo;
    logic [ACC_W-1:0] hi;
    logic             af;
    logic             cf;
  } adj_res_t;
endpackage

// File: rtl/dec_adjust_unpacked.sv
module dec_adjust_unpacked
  import dec_adjust_pkg::*;
(
  input  logic [ACC_W-1:0] lo_i,
  input  logic [ACC_W-1:0] hi_i,
  input  logic             af_i,
  output adj_res_t         res_o
);
  localparam logic [ACC_W-1:0] SIX      = ACC_W'(6);
  localparam logic [ACC_W-1:0] LOW_MASK = ACC_W'((1 << NIB_W) - 1);
  localparam logic [ACC_W-1:0] OVF_LIM  = {ACC_W{1'b1}} - SIX;

  logic fix, ovf;

  always_comb begin
    fix = (lo_i[NIB_W-1:0] > NIB_W'(DIGIT_MAX)) || af_i;
    ovf = lo_i > OVF_LIM;  // extra carry into the high byte
    if (fix) begin
      res_o.lo = (lo_i + SIX) & LOW_MASK;
      res_o.hi = hi_i + ACC_W'(1) + ACC_W'(ovf);
      res_o.af = 1'b1;
      res_o.cf = 1'b1;
    end else begin
      res_o.lo = lo_i & LOW_MASK;
      res_o.hi = hi_i;
      res_o.af = 1'b0;
      res_o.cf = 1'b0;
    end
  end

  always_comb begin
    assert (res_o.lo[ACC_W-1:NIB_W] == '0);  // R1, R3: single digit left
  end
endmodule

// File: rtl/dec_adjust_packed.sv
module dec_adjust_packed
  import dec_adjust_pkg::*;
(
  input  logic [ACC_W-1:0] lo_i,
  input  logic [ACC_W-1:0] hi_i,
  input  logic             af_i,
  input  logic             cf_i,
  output adj_res_t         res_o
);
  localparam logic [ACC_W-1:0] LO_STEP  = ACC_W'(6);
  localparam logic [ACC_W-1:0] HI_STEP  = ACC_W'(6 << NIB_W);
  localparam logic [ACC_W-1:0] HI_MASK  = ~ACC_W'((1 << NIB_W) - 1);
  localparam logic [ACC_W-1:0] HI_LIM   = ACC_W'(DIGIT_MAX << NIB_W);

  logic             lo_fix, hi_fix;
  logic [ACC_W-1:0] step;

  always_comb begin
    lo_fix   = (lo_i[NIB_W-1:0] > NIB_W'(DIGIT_MAX)) || af_i;
    // high test on the incoming byte, not on step
    hi_fix   = ((lo_i & HI_MASK) > HI_LIM) || cf_i;
    step     = lo_i + (lo_fix ? LO_STEP : '0);
    res_o.lo = step + (hi_fix ? HI_STEP : '0);
    res_o.hi = hi_i;
    res_o.af = lo_fix;
    res_o.cf = hi_fix;
  end
endmodule

// File: rtl/dec_adjust.sv
module dec_adjust
  import dec_adjust_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             op_i,
  input  logic [ACC_W-1:0] lo_i,
  input  logic [ACC_W-1:0] hi_i,
  input  logic             af_i,
  input  logic             cf_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] lo_o,
  output logic [ACC_W-1:0] hi_o,
  output logic             af_o,
  output logic             cf_o
);
  adj_res_t res_unp, res_pak, res_sel, res_q;
  logic     valid_q;

  dec_adjust_unpacked u_unpacked (
    .lo_i (lo_i),
    .hi_i (hi_i),
    .af_i (af_i),
    .res_o(res_unp)
  );

  dec_adjust_packed u_packed (
    .lo_i (lo_i),
    .hi_i (hi_i),
    .af_i (af_i),
    .cf_i (cf_i),
    .res_o(res_pak)
  );

  always_comb res_sel = (adj_op_e'(op_i) == OP_PACKED) ? res_pak : res_unp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_sel;
    end
  end

  assign valid_o = valid_q;
  assign lo_o    = res_q.lo;
  assign hi_o    = res_q.hi;
  assign af_o    = res_q.af;
  assign cf_o    = res_q.cf;

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(lo_o) && $stable(hi_o) && $stable(af_o) && $stable(cf_o));
  p_unp_flags_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_i |=> af_o == cf_o);
  p_unp_fix_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_i && af_i |=> af_o && cf_o);
  p_pak_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i |=> hi_o == $past(hi_i));
  p_pak_cf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i && cf_i |=> cf_o);
  p_pak_af_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i && af_i |=> af_o);
endmodule

// File: tb/test_dec_adjust.sv
module test_dec_adjust;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0, op_i = 1'b0, af_i = 1'b0, cf_i = 1'b0;
  logic [7:0] lo_i = '0, hi_i = '0;
  logic       valid_o, af_o, cf_o;
  logic [7:0] lo_o, hi_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       af;
    logic       cf;
    logic       op;
  } exp_t;

  exp_t sb_q[$];
  exp_t last;

  always #4 clk = ~clk;  // 125 MHz

  dec_adjust i_dec_adjust (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .lo_i(lo_i), .hi_i(hi_i), .af_i(af_i), .cf_i(cf_i),
    .valid_o(valid_o), .lo_o(lo_o), .hi_o(hi_o), .af_o(af_o), .cf_o(cf_o)
  );

  function automatic exp_t model(bit op, logic [7:0] lo, logic [7:0] hi, bit af, bit cf);
    exp_t e;
    e.op = op;
    if (!op) begin
      if (lo[3:0] > 4'd9 || af) begin  // R1, R2
        e.lo = 8'((lo + 8'd6) & 8'h0F);
        e.hi = 8'(hi + 8'd1 + ((lo > 8'hF9) ? 8'd1 : 8'd0));
        e.af = 1; e.cf = 1;
      end else begin  // R3
        e.lo = lo & 8'h0F; e.hi = hi; e.af = 0; e.cf = 0;
      end
    end else begin  // R4, R5, R6, R7
      logic [7:0] t;
      t = lo;
      e.af = (lo[3:0] > 4'd9) || af;
      if (e.af) t = 8'(t + 8'h06);
      e.cf = ((lo & 8'hF0) > 8'h90) || cf;
      if (e.cf) t = 8'(t + 8'h60);
      e.lo = t; e.hi = hi;
    end
    return e;
  endfunction

  task automatic drive(bit op, logic [7:0] lo, logic [7:0] hi, bit af, bit cf);
    @(negedge clk);
    op_i = op; lo_i = lo; hi_i = hi; af_i = af; cf_i = cf; valid_i = 1;
    sb_q.push_back(model(op, lo, hi, af, cf));
    @(negedge clk);
    valid_i = 0;
  endtask

  // back-to-back strobes
  task automatic drive_burst(bit op, logic [7:0] lo, logic [7:0] hi, bit af, bit cf);
    @(negedge clk);
    op_i = op; lo_i = lo; hi_i = hi; af_i = af; cf_i = cf; valid_i = 1;
    sb_q.push_back(model(op, lo, hi, af, cf));
  endtask

  task automatic check_out(string req, exp_t e);
    checks++;
    if (lo_o !== e.lo || hi_o !== e.hi || af_o !== e.af || cf_o !== e.cf) begin
      errors++;
      $display("FAIL %s op=%0d: got lo=%h hi=%h af=%0d cf=%0d, exp lo=%h hi=%h af=%0d cf=%0d",
               req, e.op, lo_o, hi_o, af_o, cf_o, e.lo, e.hi, e.af, e.cf);
    end
  endtask

  // monitor: results due one edge after the strobe, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done && valid_o) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: valid_o=1 with no pending item, exp valid_o=0");
      end else begin
        last = sb_q.pop_front();
        check_out(last.op ? "R4/R5/R6/R7" : "R1/R2/R3/R7", last);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run not finished, exp finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_t z;
    z = '0;
    repeat (2) @(negedge clk);
    // R9: reset state
    checks++;
    if (valid_o !== 0 || lo_o !== 0 || hi_o !== 0 || af_o !== 0 || cf_o !== 0) begin
      errors++;
      $display("FAIL R9: got v=%0d lo=%h hi=%h af=%0d cf=%0d, exp all 0",
               valid_o, lo_o, hi_o, af_o, cf_o);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);
    checks++;
    if (valid_o !== 0) begin
      errors++; $display("FAIL R9: valid_o=%0d after reset release, exp 0", valid_o);
    end

    drive(0, 8'h66, 8'h00, 0, 0);  // R3 example -> 0x06
    drive(0, 8'h0A, 8'h12, 0, 0);  // R1 -> 00,13,1,1
    drive(0, 8'h03, 8'h40, 1, 0);  // R1 via af
    drive(0, 8'hFA, 8'h20, 0, 0);  // R2 -> hi+2
    drive(0, 8'hF9, 8'h20, 1, 0);  // R2 boundary: not above F9 -> hi+1
    drive(0, 8'h05, 8'hFF, 1, 0);  // R7 wrap hi -> 00
    drive(0, 8'hFF, 8'hFE, 0, 0);  // R2, R7 -> hi 00
    drive(0, 8'h39, 8'h07, 0, 1);  // R3: cf_i ignored
    drive(1, 8'h9A, 8'h55, 0, 0);  // R5 uses original byte -> A0, cf 0
    drive(1, 8'h45, 8'h11, 0, 1);  // R5 via cf -> A5
    drive(1, 8'hA5, 8'h22, 0, 0);  // R5, R7 -> 05
    drive(1, 8'hFF, 8'h33, 0, 0);  // R4, R5, R7 -> 65
    drive(1, 8'h99, 8'h44, 1, 0);  // R4 via af, 0x90 not above -> 9F
    drive(1, 8'h12, 8'h66, 0, 0);  // R4, R5 no fix, R6

    // R8: outputs hold while idle
    repeat (3) @(negedge clk);
    check_out("R8 hold", last);
    checks++;
    if (valid_o !== 0) begin
      errors++; $display("FAIL R8: valid_o=%0d while idle, exp 0", valid_o);
    end

    // R8: back-to-back strobes, one pulse per strobe
    drive_burst(0, 8'h0B, 8'h01, 0, 0);
    drive_burst(1, 8'h9B, 8'h02, 0, 0);
    drive_burst(1, 8'h27, 8'h03, 1, 1);
    @(negedge clk); valid_i = 0;
    repeat (3) @(negedge clk);

    // sweep every low byte in both modes with varied flags
    for (int v = 0; v < 256; v++) begin
      drive(0, 8'(v), 8'(v * 7), v[0], v[1]);
      drive(1, 8'(v), 8'(v * 3), v[1], v[2]);
    end
    repeat (3) @(negedge clk);

    checks++;
    if (sb_q.size() != 0) begin
      errors++; $display("FAIL R8: %0d results missing, exp 0", sb_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule